// File: doc/BRIEF.md
# Two-Port Register File with Flag-Based Reset

This block is a small register file with two read/write ports on one clock. Its storage is a plain inferred RAM array that has no reset of its own. A short, fixed range of low addresses still needs defined values after reset. For each address in that range the block keeps one "written" flip-flop. Synchronous reset clears these flip-flops. When such an address is read while its flip-flop is still clear, the block returns a per-address constant from a parameter in place of whatever the RAM holds.

Each port has an enable, a write strobe, an address, write data and read data. Reads are registered, so data appears one clock after the enable. The substitution decision is registered on the same edge as the RAM read, so the value chosen always matches the address that was read. Addresses above the reset range carry no flag, and reads of them always return RAM contents. This keeps the flag logic small when the array is large.

Top module: `regfile_rstflag`

## Requirements
- R1: A port with enable and write strobe both high at a clock edge stores its write data at its address. A later read of that address from either port returns that data.
- R2: A port with enable high at an edge loads its read-data output on that edge. With enable low, the output holds its previous value.
- R3: Synchronous reset clears every written flag. After reset, a read of address i below NUM_RST, with its flag clear, returns `RESET_VALUES[i*DATA_W +: DATA_W]`, even if the RAM holds other data for that address.
- R4: A write to a flagged address through either port sets that address's flag. The flag stays set until the next reset, and reads then return RAM contents.
- R5: Addresses at or above NUM_RST have no flag, and reads of them always return RAM contents.
- R6: A read at the same edge as a write to the same address, by either port, returns the value from before the write. If the flag was clear before that edge, this is the reset constant.
- R7: When both ports write the same address at one edge, port A's data is stored and the flag for that address is set.
- R8: While reset is high, writes on both ports are ignored and both read-data outputs are zero from the first edge of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| aEn | input | 1 | Port A enable (read on every enabled edge) |
| aWe | input | 1 | Port A write strobe |
| aAddr | input | ADDR_W | Port A address |
| aWdata | input | DATA_W | Port A write data |
| aRdata | output | DATA_W | Port A registered read data |
| bEn | input | 1 | Port B enable (read on every enabled edge) |
| bWe | input | 1 | Port B write strobe |
| bAddr | input | ADDR_W | Port B address |
| bWdata | input | DATA_W | Port B write data |
| bRdata | output | DATA_W | Port B registered read data |

## Verification
The hardest case to reach is a mid-run reset after the reset-range addresses already hold real data. The RAM keeps those stale words, and only the cleared flags hide them. The stimulus writes known data to addresses 0 to 2, resets again, and reads them back, so the constants must win over the RAM. Same-edge write/read pairs across the two ports are also driven. These include a write by one port to a never-written flagged address while the other port reads it, which checks that the old flag is used. A long random phase on addresses 0 to 7 with sparse resets then mixes collisions and reset-range accesses. A behavioural model is compared against the outputs on every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // strobes from control to datapath, already qualified by reset and collision
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic rdA;
    logic rdB;
    logic clr;
  } rfStrobes_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NUM_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aEn,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              bEn,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  output rfStrobes_t        strb,
  output logic              subA,
  output logic              subB
);

  logic [NUM_RST-1:0] written;
  logic [NUM_RST-1:0] hitA;
  logic [NUM_RST-1:0] hitB;
  logic               sameAddr;

  // address decode for the flagged region only
  for (genvar i = 0; i < NUM_RST; i++) begin : g_hit
    assign hitA[i] = (aAddr == ADDR_W'(i));
    assign hitB[i] = (bAddr == ADDR_W'(i));
  end

  assign sameAddr = (aAddr == bAddr);

  always_comb begin
    strb.clr = rst;
    strb.rdA = !rst && aEn;
    strb.rdB = !rst && bEn;
    strb.wrA = !rst && aEn && aWe;
    // port A wins a same-address collision
    strb.wrB = !rst && bEn && bWe && !(aEn && aWe && sameAddr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else begin
      written <= written
               | (hitA & {NUM_RST{strb.wrA}})
               | (hitB & {NUM_RST{strb.wrB}});
    end
  end

  // substitution bit registered with the RAM read, using the pre-write flag
  always_ff @(posedge clk) begin
    if (rst) begin
      subA <= 1'b0;
      subB <= 1'b0;
    end else begin
      if (strb.rdA) subA <= |(hitA & ~written);
      if (strb.rdB) subB <= |(hitB & ~written);
    end
  end

  assert_flags_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (written == '0));

  for (genvar i = 0; i < NUM_RST; i++) begin : g_chk
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
      ((strb.wrA && hitA[i]) || (strb.wrB && hitB[i])) |=> written[i]);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      written[i] |=> written[i]);
  end

endmodule

// File: rtl/rf_data.sv
module rf_data
  import rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int NUM_RST = 3,
  parameter logic [NUM_RST*DATA_W-1:0] RESET_VALUES = '0
) (
  input  logic              clk,
  input  rfStrobes_t        strb,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  input  logic              subA,
  input  logic              subB,
  output logic [DATA_W-1:0] aRdata,
  output logic [DATA_W-1:0] bRdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memQA;
  logic [DATA_W-1:0] memQB;
  logic [ADDR_W-1:0] addrQA;
  logic [ADDR_W-1:0] addrQB;
  logic [DATA_W-1:0] rstValA;
  logic [DATA_W-1:0] rstValB;

  // storage: no reset on the array
  always_ff @(posedge clk) begin
    if (strb.wrB) mem[bAddr] <= bWdata;
    if (strb.wrA) mem[aAddr] <= aWdata;
  end

  // read-first output registers
  always_ff @(posedge clk) begin
    if (strb.clr) begin
      memQA  <= '0;
      memQB  <= '0;
      addrQA <= '0;
      addrQB <= '0;
    end else begin
      if (strb.rdA) begin
        memQA  <= mem[aAddr];
        addrQA <= aAddr;
      end
      if (strb.rdB) begin
        memQB  <= mem[bAddr];
        addrQB <= bAddr;
      end
    end
  end

  always_comb begin
    rstValA = '0;
    rstValB = '0;
    for (int i = 0; i < NUM_RST; i++) begin
      if (addrQA == ADDR_W'(i)) rstValA = RESET_VALUES[i*DATA_W +: DATA_W];
      if (addrQB == ADDR_W'(i)) rstValB = RESET_VALUES[i*DATA_W +: DATA_W];
    end
  end

  assign aRdata = subA ? rstValA : memQA;
  assign bRdata = subB ? rstValB : memQB;

  assert_a_wins_R7: assert property (@(posedge clk) disable iff (strb.clr)
    strb.wrA |=> (mem[$past(aAddr)] == $past(aWdata)));

  assert_no_write_in_rst_R8: assert property (@(posedge clk)
    strb.clr |-> !(strb.wrA || strb.wrB));

  assert_zero_out_R8: assert property (@(posedge clk) disable iff (strb.clr)
    $fell(strb.clr) |-> (aRdata == '0 && bRdata == '0));

endmodule

// File: rtl/regfile_rstflag.sv
module regfile_rstflag
  import rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int NUM_RST = 3,
  parameter logic [NUM_RST*DATA_W-1:0] RESET_VALUES =
    {32'h0000_00A5, 32'h8000_0000, 32'hFFFF_0001}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aEn,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  input  logic              bEn,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata
);

  rfStrobes_t strb;
  logic       subA;
  logic       subB;

  rf_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_RST(NUM_RST)
  ) ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .aEn  (aEn),
    .aWe  (aWe),
    .aAddr(aAddr),
    .bEn  (bEn),
    .bWe  (bWe),
    .bAddr(bAddr),
    .strb (strb),
    .subA (subA),
    .subB (subB)
  );

  rf_data #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_RST     (NUM_RST),
    .RESET_VALUES(RESET_VALUES)
  ) data_i (
    .clk   (clk),
    .strb  (strb),
    .aAddr (aAddr),
    .aWdata(aWdata),
    .bAddr (bAddr),
    .bWdata(bWdata),
    .subA  (subA),
    .subB  (subB),
    .aRdata(aRdata),
    .bRdata(bRdata)
  );

endmodule

// File: tb/regfile_rstflag_tb_top.sv
module regfile_rstflag_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, aEn, aWe, bEn, bWe;
  logic [4:0]  aAddr, bAddr;
  logic [31:0] aWdata, bWdata, aRdata, bRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_rstflag dut_i (
    .clk(clk), .rst(rst),
    .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata)
  );

  // behavioural reference state
  logic [31:0] mdlMem [32];
  bit          mdlKnown [32];
  bit          mdlFlag [3];
  logic [31:0] expA, expB;
  bit          knownA, knownB;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  string       curTag = "R8";

  function automatic logic [31:0] rstConst(int i);
    case (i)
      0: return 32'hFFFF_0001;
      1: return 32'h8000_0000;
      default: return 32'h0000_00A5;
    endcase
  endfunction

  task automatic mdlRead(input int adr, output logic [31:0] v, output bit k);
    if (adr < 3 && !mdlFlag[adr]) begin
      v = rstConst(adr); k = 1;
    end else begin
      v = mdlMem[adr]; k = mdlKnown[adr];
    end
  endtask

  task automatic compare();
    if (knownA) begin
      checks++;
      if (aRdata !== expA) begin
        fails++;
        $display("FAIL %s port A: got %h expected %h", curTag, aRdata, expA);
      end
    end
    if (knownB) begin
      checks++;
      if (bRdata !== expB) begin
        fails++;
        $display("FAIL %s port B: got %h expected %h", curTag, bRdata, expB);
      end
    end
  endtask

  task automatic step(input bit r, input bit ae, input bit awe, input int aa,
                      input logic [31:0] ad, input bit be, input bit bwe,
                      input int ba, input logic [31:0] bd);
    logic [31:0] va, vb;
    bit ka, kb;
    rst = r; aEn = ae; aWe = awe; aAddr = aa[4:0]; aWdata = ad;
    bEn = be; bWe = bwe; bAddr = ba[4:0]; bWdata = bd;
    @(posedge clk);
    if (r) begin
      expA = '0; expB = '0; knownA = 1; knownB = 1;
      for (int i = 0; i < 3; i++) mdlFlag[i] = 0;
    end else begin
      mdlRead(aa, va, ka);
      mdlRead(ba, vb, kb);
      if (be && bwe) begin
        mdlMem[ba] = bd; mdlKnown[ba] = 1;
        if (ba < 3) mdlFlag[ba] = 1;
      end
      if (ae && awe) begin
        mdlMem[aa] = ad; mdlKnown[aa] = 1;
        if (aa < 3) mdlFlag[aa] = 1;
      end
      if (ae) begin expA = va; knownA = ka; end
      if (be) begin expB = vb; knownB = kb; end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) mdlKnown[i] = 0;
    knownA = 0; knownB = 0;
    // R8: writes during reset are dropped, outputs zero
    curTag = "R8";
    for (int n = 0; n < 3; n++) step(1, 1, 1, 0, 32'h1111_1111, 1, 1, 1, 32'h2222_2222);
    // R3: flagged addresses return constants
    curTag = "R3";
    step(0, 1, 0, 0, 0, 1, 0, 1, 0);
    step(0, 1, 0, 2, 0, 1, 0, 0, 0);
    // R4: a write through B sets the flag, reads then show RAM data
    curTag = "R4";
    step(0, 0, 0, 0, 0, 1, 1, 1, 32'hABCD_0001);
    step(0, 1, 0, 1, 0, 1, 0, 1, 0);
    // R6: A writes address 0 while B reads it: the old constant comes back
    curTag = "R6";
    step(0, 1, 1, 0, 32'h1234_5678, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1, 0, 0, 0);
    // R1 / R5: fill upper addresses, read back on the other port
    curTag = "R5";
    for (int a = 3; a < 32; a++) step(0, 1, 1, a, 32'h5A00_0000 ^ (a * 32'h0101_0307), 1, 0, a - 1, 0);
    curTag = "R1";
    for (int a = 3; a < 32; a++) step(0, 1, 0, 34 - a, 0, 1, 0, a, 0);
    // R6: B writes flagged address 2 while A reads it; then plain address 10
    curTag = "R6";
    step(0, 1, 0, 2, 0, 1, 1, 2, 32'hCAFE_0002);
    step(0, 1, 0, 2, 0, 1, 0, 2, 0);
    step(0, 1, 1, 10, 32'h0000_0010, 1, 0, 10, 0);
    step(0, 1, 0, 10, 0, 1, 0, 10, 0);
    // R7: collision on a plain address and on a flagged one after reset
    curTag = "R7";
    step(0, 1, 1, 7, 32'hAAAA_0007, 1, 1, 7, 32'hBBBB_0007);
    step(0, 1, 0, 7, 0, 1, 0, 7, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 1, 32'hAAAA_0001, 1, 1, 1, 32'hBBBB_0001);
    step(0, 1, 0, 1, 0, 1, 0, 2, 0);
    // R2: enables low hold the outputs
    curTag = "R2";
    step(0, 0, 1, 1, 32'hDEAD_0000, 0, 1, 2, 32'hDEAD_0001);
    step(0, 0, 0, 5, 0, 0, 0, 6, 0);
    step(0, 1, 0, 1, 0, 1, 0, 2, 0);
    // R3: mid-run reset hides data already written to flagged addresses
    curTag = "R3";
    step(0, 1, 1, 0, 32'h0F0F_0F0F, 1, 1, 2, 32'hF0F0_F0F0);
    step(0, 1, 0, 0, 0, 1, 0, 2, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1, 0, 2, 0);
    step(0, 1, 0, 1, 0, 1, 0, 3, 0);
    // R1: random traffic on a small address window
    curTag = "R1";
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 99) == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 7), $urandom, $urandom_range(0, 3) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom);
    finishRun();
  end
endmodule